// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block chooses which page frame to evict when a page fault must be served. It holds one reference bit per frame and a hand pointer that walks the frames as a ring. A lookup path that sees a frame being touched raises an access strobe with the frame index, and that frame's reference bit becomes 1.

When a fault request arrives, the controller starts at the hand and looks at one frame per clock cycle. A frame whose bit is 1 loses the bit and is passed over. The first frame found with its bit at 0 is the victim. The incoming page takes that slot and is marked as referenced. The hand always stops one place past the frame it looked at last. The victim index is reported together with a one-cycle done pulse. The search length depends on the reference bits, and the longest search is one full lap plus one frame.

The controller has three states. `ST_IDLE` waits for a request, and a request moves it to `ST_SCAN`. `ST_SCAN` stays in `ST_SCAN` while the examined bit is 1 (the clear-and-skip transition) and moves to `ST_DONE` when the examined bit is 0 (the evict transition). `ST_DONE` returns to `ST_IDLE` unconditionally after one cycle.

Top module: `pgclk_evict`

## Requirements
- R1: After reset every reference bit is 0, the hand is at frame 0, and busy and done are low.
- R2: An access strobe with index k makes reference bit k read 1 from the next cycle on.
- R3: A fault request seen while busy is low raises busy in the next cycle. Busy then stays high through the cycle that carries the done pulse. The first frame examined is the one under the hand when busy rises.
- R4: When the examined frame's bit is 1, that bit is cleared, the hand advances by one, and the scan continues without choosing a victim.
- R5: When the examined frame's bit is 0, that frame becomes the victim and its bit is set to 1 for the new page. The hand advances by one. In the following cycle done is high and the victim output carries that index.
- R6: The hand only ever moves by one position per cycle, and it goes from frame N-1 to frame 0.
- R7: If an access strobe names the frame being cleared by the scan in the same cycle, the bit ends up 1.
- R8: With no access strobes during a scan, busy stays high for at most N+2 cycles. When all bits are 1 at the start, busy stays high for exactly N+2 cycles and the victim is the frame where the hand started.
- R9: A fault request raised while busy is high has no effect on the hand, the bits or the victim.
- R10: Done is high for exactly one cycle per accepted request, and only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe: a frame was touched |
| acc_frame | input | $clog2(N) | Index of the touched frame |
| fault_req | input | 1 | Request a victim search |
| busy | output | 1 | Search in progress, through the done cycle |
| done | output | 1 | One-cycle pulse: victim is valid |
| victim | output | $clog2(N) | Chosen frame index |
| hand | output | $clog2(N) | Current hand position |
| ref_bits | output | N | Reference bit of every frame |

## Verification
The access port and the scan can act on the same frame in the same cycle. The scan wants to clear the bit and the access wants to set it. The bench sets every bit, issues a fault, and then drives an access strobe at the frame under the hand during the first scan cycle. The set must win, so that frame survives the first lap and is cleared on the second pass, which puts the victim one frame further on. A fault request that lands during a scan is provoked the same way, and it is judged by confirming that exactly one done pulse appears. A behavioural model compares every output on every cycle.

// File: rtl/pgclk_pkg.sv
package pgclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;
endpackage

// File: rtl/pgclk_refbits.sv
// One reference bit per frame. Priority per bit: set (access or insert) over clear.
module pgclk_refbits #(
    parameter int N = 8,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IDXW-1:0] set_idx,
    input  logic            clr_en,
    input  logic            ins_en,
    input  logic [IDXW-1:0] sel_idx,
    output logic [N-1:0]    bits
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic hit_set, hit_sel;
        assign hit_set = set_en && (set_idx == IDXW'(i));
        assign hit_sel = (sel_idx == IDXW'(i));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits[i] <= 1'b0;
            end else if (hit_set || (ins_en && hit_sel)) begin
                bits[i] <= 1'b1;
            end else if (clr_en && hit_sel) begin
                bits[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgclk_hand.sv
// Circular pointer over N frames.
module pgclk_hand #(
    parameter int N = 8,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [IDXW-1:0] ptr
);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/pgclk_ctrl.sv
// Scan controller: one frame examined per cycle in ST_SCAN.
module pgclk_ctrl
    import pgclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_req,
    input  logic hand_bit,
    output logic adv,
    output logic clr_en,
    output logic ins_en,
    output logic busy,
    output logic done
);
    scan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fault_req) state_d = ST_SCAN;
            ST_SCAN: if (!hand_bit) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        adv    = 1'b0;
        clr_en = 1'b0;
        ins_en = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SCAN: begin
                busy   = 1'b1;
                adv    = 1'b1;
                clr_en = hand_bit;
                ins_en = !hand_bit;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pgclk_evict.sv
module pgclk_evict #(
    parameter int N = 8,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [IDXW-1:0] acc_frame,
    input  logic            fault_req,
    output logic            busy,
    output logic            done,
    output logic [IDXW-1:0] victim,
    output logic [IDXW-1:0] hand,
    output logic [N-1:0]    ref_bits
);
    logic adv, clr_en, ins_en;
    logic [IDXW-1:0] victim_q;

    pgclk_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_req(fault_req),
        .hand_bit (ref_bits[hand]),
        .adv      (adv),
        .clr_en   (clr_en),
        .ins_en   (ins_en),
        .busy     (busy),
        .done     (done)
    );

    pgclk_hand #(.N(N)) u_hand (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .ptr  (hand)
    );

    pgclk_refbits #(.N(N)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (acc_valid),
        .set_idx(acc_frame),
        .clr_en (clr_en),
        .ins_en (ins_en),
        .sel_idx(hand),
        .bits   (ref_bits)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      victim_q <= '0;
        else if (ins_en) victim_q <= hand;
    end
    assign victim = victim_q;
endmodule

// File: rtl/pgclk_evict_chk.sv
module pgclk_evict_chk #(
    parameter int N = 8,
    localparam int IDXW = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [IDXW-1:0] acc_frame,
    input logic            fault_req,
    input logic            busy,
    input logic            done,
    input logic [IDXW-1:0] victim,
    input logic [IDXW-1:0] hand,
    input logic [N-1:0]    ref_bits
);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);
    logic [31:0] busy_cnt;
    logic        clean_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_cnt <= '0;
            clean_q  <= 1'b1;
        end else begin
            busy_cnt <= busy_cnt + 1;
            if (acc_valid) clean_q <= 1'b0;
        end
    end

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fault_req) |=> (busy && $stable(hand)));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ref_bits[$past(acc_frame)]);
    a_r5_victim_marked: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ref_bits[victim]);
    a_r6_hand_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hand != $past(hand)) |->
        (hand == (($past(hand) == LAST) ? '0 : $past(hand) + 1'b1)));
    a_r9_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> $stable(hand));
    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clean_q) |-> (busy_cnt <= 32'(N + 1)));
endmodule

bind pgclk_evict pgclk_evict_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_frame(acc_frame),
    .fault_req(fault_req),
    .busy     (busy),
    .done     (done),
    .victim   (victim),
    .hand     (hand),
    .ref_bits (ref_bits)
);

// File: tb/sim_pgclk_evict.sv
`timescale 1ns/1ps
module sim_pgclk_evict;
    localparam int N = 8;
    localparam int IDXW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [IDXW-1:0] acc_frame = '0;
    logic fault_req = 1'b0;
    logic busy, done;
    logic [IDXW-1:0] victim, hand;
    logic [N-1:0] ref_bits;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pgclk_evict #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
        .fault_req(fault_req), .busy(busy), .done(done), .victim(victim),
        .hand(hand), .ref_bits(ref_bits)
    );

    // Behavioural reference model: 0 idle, 1 searching, 2 reporting
    int m_phase, m_hand, m_victim;
    bit m_ref[N];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_hand = 0; m_victim = 0;
            foreach (m_ref[i]) m_ref[i] = 0;
        end else begin
            if (m_phase == 0) begin
                if (fault_req) m_phase = 1;
            end else if (m_phase == 1) begin
                if (m_ref[m_hand]) begin
                    m_ref[m_hand] = 0;
                end else begin
                    m_victim = m_hand;
                    m_ref[m_hand] = 1;
                    m_phase = 2;
                end
                m_hand = (m_hand + 1) % N;
            end else begin
                m_phase = 0;
            end
            if (acc_valid) m_ref[acc_frame] = 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (m_phase != 0), "R3 busy", busy, m_phase != 0);
            check(done == (m_phase == 2), "R10 done", done, m_phase == 2);
            check(hand == IDXW'(m_hand), "R6 hand", hand, m_hand);
            for (int i = 0; i < N; i++)
                check(ref_bits[i] == m_ref[i], "R4 ref bit", ref_bits[i], m_ref[i]);
            if (m_phase == 2)
                check(victim == IDXW'(m_victim), "R5 victim", victim, m_victim);
        end
    end

    task automatic touch(input int f);
        @(negedge clk); acc_valid = 1'b1; acc_frame = IDXW'(f);
        @(negedge clk); acc_valid = 1'b0;
    endtask

    task automatic run_fault(output int busy_cycles, output int vic);
        @(negedge clk); fault_req = 1'b1;
        @(negedge clk); fault_req = 1'b0;
        busy_cycles = 0; vic = -1;
        while (busy) begin
            busy_cycles++;
            if (done) vic = victim;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bc, v, dones, start;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ref_bits == '0, "R1 bits", ref_bits, 0);
        check(hand == '0 && !busy && !done, "R1 hand/busy", hand, 0);

        // R5 all clear: victim is frame 0, hand 1
        run_fault(bc, v);
        check(v == 0, "R5 victim", v, 0);
        check(hand == 1, "R5 hand", hand, 1);
        check(ref_bits[0] == 1'b1, "R5 insert bit", ref_bits[0], 1);

        // R2 / R4 skip two set frames
        touch(1); touch(2);
        check(ref_bits[2:1] == 2'b11, "R2 set", ref_bits[2:1], 3);
        run_fault(bc, v);
        check(v == 3, "R4 victim", v, 3);
        check(ref_bits[2:1] == 2'b00, "R4 cleared", ref_bits[2:1], 0);

        // R8 / R6 all set: full lap with wrap
        for (int f = 0; f < N; f++) touch(f);
        start = hand;
        run_fault(bc, v);
        check(bc == N + 2, "R8 lap length", bc, N + 2);
        check(v == start, "R8 victim", v, start);

        // R7 access collides with scan clear on the first examined frame
        for (int f = 0; f < N; f++) touch(f);
        start = hand;
        @(negedge clk); fault_req = 1'b1;
        @(negedge clk); fault_req = 1'b0; acc_valid = 1'b1; acc_frame = IDXW'(start);
        @(negedge clk); acc_valid = 1'b0;
        check(ref_bits[start] == 1'b1, "R7 set wins", ref_bits[start], 1);
        v = -1;
        while (busy) begin
            if (done) v = victim;
            @(negedge clk);
        end
        check(v == (start + 1) % N, "R7 victim", v, (start + 1) % N);

        // R9 fault while busy is ignored
        for (int f = 0; f < N; f++) touch(f);
        @(negedge clk); fault_req = 1'b1;
        @(negedge clk);
        @(negedge clk); fault_req = 1'b0;
        dones = 0;
        for (int c = 0; c < 3 * N; c++) begin
            if (done) dones++;
            @(negedge clk);
        end
        check(dones == 1, "R9 single done", dones, 1);

        // Mixed traffic
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            acc_valid = ($urandom_range(0, 2) == 0);
            acc_frame = IDXW'($urandom_range(0, N - 1));
            fault_req = ($urandom_range(0, 5) == 0);
        end
        @(negedge clk); acc_valid = 1'b0; fault_req = 1'b0;
        repeat (3 * N) @(negedge clk);
        check(!busy, "R10 settle", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule